// File: doc/BRIEF.md
# Display PLL Divider Search Engine

This block picks the divider settings of a display PLL for a requested pixel clock. A caller supplies a target dot clock in kHz and an output-mode select (panel mode or DAC/serial mode), pulses `start`, and waits for `done`. The engine then visits every combination of the reference divider, the two feedback divider fields and the first post divider, one candidate per clock. It drops every candidate whose derived values fall outside the legal window and keeps the one whose dot clock lies closest to the target.

The reference clock is fixed at 96000 kHz. Each candidate yields a composite feedback multiplier m = 5*(m1+2) + (m2+2), a total post divide p = p1*p2, a VCO frequency 96000*m/(n+2) and a dot clock vco/p. The second post divider p2 is not searched. It is fixed before the scan from the target and a mode-specific threshold. When the scan ends, the achieved dot clock of the winner is produced by a short sequential divider.

The interface has no stream and no back-pressure. `start` is a plain request that is taken only while `busy` is low. `done` is a one-cycle strobe, and the results then stay put until the next request is accepted, so the caller may sample them at any time in between.

Top module: `pll_div_search`

## Requirements
- R1: `start` is accepted only while `busy` is low; a `start` pulse seen while `busy` is high is ignored and does not change the result of the search in progress.
- R2: p2 is latched at acceptance: with `lvds_mode`=0 (DAC/serial) it is 10 for targets below 200000 kHz and 5 otherwise; with `lvds_mode`=1 (panel) it is 14 for targets below 112000 kHz and 7 otherwise.
- R3: A reported result satisfies n in 1..6, m1 in 8..18, m2 in 3..7, p1 in 1..8, m in 70..120, p in 5..80 (DAC/serial) or 7..98 (panel), vco in 1400000..2800000 kHz and dot in 20000..400000 kHz, where vco and dot are truncated integer quotients.
- R4: Among legal candidates, the chosen one minimises |96000*m/((n+2)*p) - target| computed exactly. Candidates are visited with n outermost ascending, then m1, then m2, and p1 innermost. On a tie the earlier candidate wins.
- R5: `dot_khz` equals floor(96000*m/((n+2)*p)) of the chosen candidate.
- R6: `fp_word` holds n in bits [23:16], m1 in bits [15:8] and m2 in bits [7:0].
- R7: `post_word` has exactly bit 16+(p1-1) set and all other bits clear.
- R8: `dual_chan` is high exactly when a result was found in panel mode with p2 = 7.
- R9: When no candidate is legal, `found` is low and the dividers, `fp_word`, `post_word`, `dot_khz` and `dual_chan` are all zero at `done`.
- R10: `busy` rises in the cycle after acceptance and stays high until the cycle after `done`. `done` is high for exactly one cycle, at most 2640 + 24 + 4 cycles after acceptance.
- R11: While idle and without a new `start`, all result outputs hold their values.
- R12: After reset, `busy`, `done` and `found` are low and `post_word` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request a search (taken when idle) |
| lvds_mode | input | 1 | 1 = panel mode, 0 = DAC/serial mode |
| target_khz | input | TGT_W | Requested dot clock in kHz |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle completion strobe |
| found | output | 1 | A legal candidate was chosen |
| n_div | output | 4 | Chosen reference divider |
| m1_div | output | 5 | Chosen coarse feedback field |
| m2_div | output | 3 | Chosen fine feedback field |
| p1_div | output | 4 | Chosen first post divider |
| p2_div | output | 4 | Second post divider in use |
| dual_chan | output | 1 | Panel dual-channel indication |
| dot_khz | output | DOT_W | Achieved dot clock in kHz |
| fp_word | output | 24 | Packed divider word |
| post_word | output | 32 | One-hot p1 post-divider field |

## Verification
On every cycle, the checker watches the handshake: that `busy` follows acceptance, that `done` is a lone strobe ending the busy period, and that results stay frozen while idle. At each `done` it also checks that any reported divider set lies within its ranges, that p2 is one of the two values for the latched mode, that `post_word` is one-hot and that an empty result is fully zero. Only the bench scenarios can show that the chosen candidate is the nearest one, that ties go to the earlier candidate, that the p2 threshold switches at the exact target value, that the achieved dot clock is right, and that a request made while busy leaves the running search untouched.

// File: rtl/pll_search_pkg.sv
package pll_search_pkg;
  localparam int N_LO  = 1;
  localparam int N_HI  = 6;
  localparam int M1_LO = 8;
  localparam int M1_HI = 18;
  localparam int M2_LO = 3;
  localparam int M2_HI = 7;
  localparam int P1_LO = 1;
  localparam int P1_HI = 8;
  localparam int M_LO  = 70;
  localparam int M_HI  = 120;
  localparam int DOT_LO = 20000;
  localparam int DOT_HI = 400000;

  localparam int DAC_P_LO    = 5;
  localparam int DAC_P_HI    = 80;
  localparam int DAC_LIM     = 200000;
  localparam int DAC_P2_SLOW = 10;
  localparam int DAC_P2_FAST = 5;
  localparam int LV_P_LO     = 7;
  localparam int LV_P_HI     = 98;
  localparam int LV_LIM      = 112000;
  localparam int LV_P2_SLOW  = 14;
  localparam int LV_P2_FAST  = 7;

  localparam int N_W  = 4;
  localparam int M1_W = 5;
  localparam int M2_W = 3;
  localparam int P1_W = 4;
  localparam int P2_W = 4;
  localparam int P_W  = 7;

  localparam int CAND_COUNT = (N_HI - N_LO + 1) * (M1_HI - M1_LO + 1) *
                              (M2_HI - M2_LO + 1) * (P1_HI - P1_LO + 1);

  typedef struct packed {
    logic [N_W-1:0]  n;
    logic [M1_W-1:0] m1;
    logic [M2_W-1:0] m2;
    logic [P1_W-1:0] p1;
  } cand_t;

  typedef enum logic [2:0] {S_IDLE, S_SCAN, S_PREP, S_DIV, S_FIN} srch_st_t;
endpackage

// File: rtl/pll_cand_iter.sv
module pll_cand_iter
  import pll_search_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  clear,
  input  logic  step,
  output cand_t cand,
  output logic  last
);
  localparam cand_t FIRST = '{n: N_W'(N_LO), m1: M1_W'(M1_LO),
                              m2: M2_W'(M2_LO), p1: P1_W'(P1_LO)};

  logic p1_top, m2_top, m1_top, n_top;

  assign p1_top = (cand.p1 == P1_W'(P1_HI));
  assign m2_top = (cand.m2 == M2_W'(M2_HI));
  assign m1_top = (cand.m1 == M1_W'(M1_HI));
  assign n_top  = (cand.n  == N_W'(N_HI));
  assign last   = p1_top & m2_top & m1_top & n_top;

  // p1 is the fastest digit, n the slowest
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cand <= FIRST;
    end else if (clear) begin
      cand <= FIRST;
    end else if (step) begin
      if (!p1_top) begin
        cand.p1 <= cand.p1 + 1'b1;
      end else begin
        cand.p1 <= P1_W'(P1_LO);
        if (!m2_top) begin
          cand.m2 <= cand.m2 + 1'b1;
        end else begin
          cand.m2 <= M2_W'(M2_LO);
          if (!m1_top) begin
            cand.m1 <= cand.m1 + 1'b1;
          end else begin
            cand.m1 <= M1_W'(M1_LO);
            cand.n  <= n_top ? N_W'(N_LO) : cand.n + 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/pll_cand_eval.sv
module pll_cand_eval
  import pll_search_pkg::*;
#(
  parameter int REF_KHZ     = 96000,
  parameter int VCO_MIN_KHZ = 1400000,
  parameter int VCO_MAX_KHZ = 2800000,
  parameter int TGT_W       = 20,
  parameter int NUM_W       = 24,
  parameter int DEN_W       = 10,
  parameter int ERR_W       = 31
) (
  input  cand_t             cand,
  input  logic [P2_W-1:0]   p2,
  input  logic [P_W-1:0]    p_lo,
  input  logic [P_W-1:0]    p_hi,
  input  logic [TGT_W-1:0]  target,
  output logic              legal,
  output logic [NUM_W-1:0]  num,
  output logic [DEN_W-1:0]  den,
  output logic [ERR_W-1:0]  err
);
  localparam int CW = 48;

  logic [CW-1:0] nd, m, p, a, d, td;
  logic m_ok, p_ok, vco_ok, dot_ok;

  // Ranges on the truncated quotients are tested by cross-multiplying:
  // floor(a/x) >= L  <=>  a >= L*x,  floor(a/x) <= H  <=>  a < (H+1)*x
  always_comb begin
    nd = CW'(cand.n) + CW'(2);
    m  = CW'(5) * (CW'(cand.m1) + CW'(2)) + CW'(cand.m2) + CW'(2);
    p  = CW'(cand.p1) * CW'(p2);
    a  = CW'(REF_KHZ) * m;
    d  = nd * p;
    td = CW'(target) * d;
    m_ok   = (m >= CW'(M_LO)) && (m <= CW'(M_HI));
    p_ok   = (p >= CW'(p_lo)) && (p <= CW'(p_hi));
    vco_ok = (a >= CW'(VCO_MIN_KHZ) * nd) && (a < (CW'(VCO_MAX_KHZ) + CW'(1)) * nd);
    dot_ok = (a >= CW'(DOT_LO) * d) && (a < (CW'(DOT_HI) + CW'(1)) * d);
    legal  = m_ok && p_ok && vco_ok && dot_ok;
    num    = NUM_W'(a);
    den    = DEN_W'(d);
    err    = ERR_W'((a > td) ? (a - td) : (td - a));
  end
endmodule

// File: rtl/pll_quot_seq.sv
module pll_quot_seq #(
  parameter int DVD_W = 24,
  parameter int DVS_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [DVD_W-1:0] dividend,
  input  logic [DVS_W-1:0] divisor,
  output logic [DVD_W-1:0] quot,
  output logic             q_valid
);
  localparam int CNT_W = $clog2(DVD_W + 1);

  logic [DVS_W-1:0] rem;
  logic [CNT_W-1:0] cnt;
  logic             run;
  logic [DVS_W:0]   shifted;
  logic             ge;

  assign shifted = {rem, quot[DVD_W-1]};
  assign ge      = (shifted >= {1'b0, divisor});

  // restoring division, one quotient bit per cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem     <= '0;
      quot    <= '0;
      cnt     <= '0;
      run     <= 1'b0;
      q_valid <= 1'b0;
    end else begin
      q_valid <= 1'b0;
      if (go) begin
        rem  <= '0;
        quot <= dividend;
        cnt  <= CNT_W'(DVD_W);
        run  <= 1'b1;
      end else if (run) begin
        rem  <= ge ? DVS_W'(shifted - {1'b0, divisor}) : shifted[DVS_W-1:0];
        quot <= {quot[DVD_W-2:0], ge};
        cnt  <= cnt - 1'b1;
        if (cnt == CNT_W'(1)) begin
          run     <= 1'b0;
          q_valid <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/pll_div_search.sv
module pll_div_search
  import pll_search_pkg::*;
#(
  parameter int TGT_W       = 20,
  parameter int DOT_W       = 20,
  parameter int REF_KHZ     = 96000,
  parameter int VCO_MIN_KHZ = 1400000,
  parameter int VCO_MAX_KHZ = 2800000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             lvds_mode,
  input  logic [TGT_W-1:0] target_khz,
  output logic             busy,
  output logic             done,
  output logic             found,
  output logic [3:0]       n_div,
  output logic [4:0]       m1_div,
  output logic [2:0]       m2_div,
  output logic [3:0]       p1_div,
  output logic [3:0]       p2_div,
  output logic             dual_chan,
  output logic [DOT_W-1:0] dot_khz,
  output logic [23:0]      fp_word,
  output logic [31:0]      post_word
);
  localparam int NUM_W = $clog2(REF_KHZ * M_HI + 1);
  localparam int DEN_W = $clog2((N_HI + 2) * P1_HI * LV_P2_SLOW + 1);
  localparam int ERR_W = TGT_W + DEN_W + 1;
  localparam int PW    = ERR_W + DEN_W;

  srch_st_t         st;
  logic [TGT_W-1:0] tgt_q;
  logic             lvds_q;
  logic [P2_W-1:0]  p2_q, p2_sel;
  logic [P_W-1:0]   plo_q, phi_q, plo_sel, phi_sel;
  logic             accept;

  cand_t            cur, bc;
  logic             last, legal, better, have;
  logic [NUM_W-1:0] num, b_num;
  logic [DEN_W-1:0] den, b_den;
  logic [ERR_W-1:0] err, b_err;
  logic [NUM_W-1:0] quot;
  logic             q_valid;
  logic [DOT_W-1:0] dot_q;

  assign accept = (st == S_IDLE) && start;

  // post-divider selection happens once, on the request
  always_comb begin
    if (lvds_mode) begin
      p2_sel  = (32'(target_khz) < 32'(LV_LIM)) ? P2_W'(LV_P2_SLOW) : P2_W'(LV_P2_FAST);
      plo_sel = P_W'(LV_P_LO);
      phi_sel = P_W'(LV_P_HI);
    end else begin
      p2_sel  = (32'(target_khz) < 32'(DAC_LIM)) ? P2_W'(DAC_P2_SLOW) : P2_W'(DAC_P2_FAST);
      plo_sel = P_W'(DAC_P_LO);
      phi_sel = P_W'(DAC_P_HI);
    end
  end

  pll_cand_iter u_iter (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (accept),
    .step  (st == S_SCAN),
    .cand  (cur),
    .last  (last)
  );

  pll_cand_eval #(
    .REF_KHZ     (REF_KHZ),
    .VCO_MIN_KHZ (VCO_MIN_KHZ),
    .VCO_MAX_KHZ (VCO_MAX_KHZ),
    .TGT_W       (TGT_W),
    .NUM_W       (NUM_W),
    .DEN_W       (DEN_W),
    .ERR_W       (ERR_W)
  ) u_eval (
    .cand   (cur),
    .p2     (p2_q),
    .p_lo   (plo_q),
    .p_hi   (phi_q),
    .target (tgt_q),
    .legal  (legal),
    .num    (num),
    .den    (den),
    .err    (err)
  );

  // err/den < b_err/b_den compared without division; strict, so ties keep the earlier
  assign better = legal && (!have ||
                  (PW'(err) * PW'(b_den) < PW'(b_err) * PW'(den)));

  pll_quot_seq #(
    .DVD_W (NUM_W),
    .DVS_W (DEN_W)
  ) u_quot (
    .clk      (clk),
    .rst_n    (rst_n),
    .go       ((st == S_PREP) && have),
    .dividend (b_num),
    .divisor  (b_den),
    .quot     (quot),
    .q_valid  (q_valid)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      tgt_q  <= '0;
      lvds_q <= 1'b0;
      p2_q   <= '0;
      plo_q  <= '0;
      phi_q  <= '0;
      have   <= 1'b0;
      bc     <= '0;
      b_num  <= '0;
      b_den  <= '0;
      b_err  <= '0;
      dot_q  <= '0;
    end else begin
      unique case (st)
        S_IDLE: if (accept) begin
          st     <= S_SCAN;
          tgt_q  <= target_khz;
          lvds_q <= lvds_mode;
          p2_q   <= p2_sel;
          plo_q  <= plo_sel;
          phi_q  <= phi_sel;
          have   <= 1'b0;
          bc     <= '0;
          b_num  <= '0;
          b_den  <= '0;
          b_err  <= '0;
          dot_q  <= '0;
        end
        S_SCAN: begin
          if (better) begin
            have  <= 1'b1;
            bc    <= cur;
            b_num <= num;
            b_den <= den;
            b_err <= err;
          end
          if (last) st <= S_PREP;
        end
        S_PREP: st <= have ? S_DIV : S_FIN;
        S_DIV: if (q_valid) begin
          dot_q <= DOT_W'(quot);
          st    <= S_FIN;
        end
        S_FIN:   st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy      = (st != S_IDLE);
  assign done      = (st == S_FIN);
  assign found     = have;
  assign n_div     = bc.n;
  assign m1_div    = bc.m1;
  assign m2_div    = bc.m2;
  assign p1_div    = bc.p1;
  assign p2_div    = have ? p2_q : '0;
  assign dual_chan = have && lvds_q && (p2_q == P2_W'(LV_P2_FAST));
  assign dot_khz   = dot_q;
  assign fp_word   = {8'(bc.n), 8'(bc.m1), 8'(bc.m2)};
  assign post_word = have ? (32'd1 << (32'(bc.p1) + 32'd15)) : 32'd0;
endmodule

// File: rtl/pll_div_search_chk.sv
module pll_div_search_chk #(
  parameter int DOT_W = 20
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             busy,
  input logic             done,
  input logic             found,
  input logic             lvds_q,
  input logic [3:0]       n_div,
  input logic [4:0]       m1_div,
  input logic [2:0]       m2_div,
  input logic [3:0]       p1_div,
  input logic [3:0]       p2_div,
  input logic             dual_chan,
  input logic [DOT_W-1:0] dot_khz,
  input logic [31:0]      post_word
);
  AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> busy); // R1
  AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy); // R10
  AST_DONE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy)); // R10
  AST_DONE_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy); // R10
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(found) && $stable(dot_khz) && $stable(n_div) &&
                           $stable(m1_div) && $stable(post_word))); // R11
  AST_DIV_RANGES: assert property (@(posedge clk) disable iff (!rst_n)
    (done && found) |-> (n_div >= 4'd1 && n_div <= 4'd6 && m1_div >= 5'd8 && m1_div <= 5'd18 &&
                         m2_div >= 3'd3 && m2_div <= 3'd7 && p1_div >= 4'd1 && p1_div <= 4'd8)); // R3
  AST_DOT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (done && found) |-> (32'(dot_khz) >= 32'd20000 && 32'(dot_khz) <= 32'd400000)); // R3
  AST_P2_DAC: assert property (@(posedge clk) disable iff (!rst_n)
    (done && found && !lvds_q) |-> (p2_div == 4'd10 || p2_div == 4'd5)); // R2
  AST_P2_PANEL: assert property (@(posedge clk) disable iff (!rst_n)
    (done && found && lvds_q) |-> (p2_div == 4'd14 || p2_div == 4'd7)); // R2
  AST_P1_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    (done && found) |-> ($countones(post_word) == 1 && post_word[15:0] == 16'd0)); // R7
  AST_DUAL_ONLY_PANEL: assert property (@(posedge clk) disable iff (!rst_n)
    dual_chan |-> (found && lvds_q)); // R8
  AST_EMPTY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !found) |-> (dot_khz == '0 && post_word == 32'd0 && n_div == 4'd0 &&
                          p2_div == 4'd0 && !dual_chan)); // R9
endmodule

bind pll_div_search pll_div_search_chk #(.DOT_W(DOT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .busy      (busy),
  .done      (done),
  .found     (found),
  .lvds_q    (lvds_q),
  .n_div     (n_div),
  .m1_div    (m1_div),
  .m2_div    (m2_div),
  .p1_div    (p1_div),
  .p2_div    (p2_div),
  .dual_chan (dual_chan),
  .dot_khz   (dot_khz),
  .post_word (post_word)
);

// File: tb/sim_pll_div_search.sv
`timescale 1ns/1ps
module sim_pll_div_search;
  localparam int TGT_W = 20;
  localparam int DOT_W = 20;
  localparam int LAT_MAX = 2640 + 24 + 4;
  localparam int NV = 10;
  localparam int V_TGT [NV] = '{25175, 65000, 108000, 199999, 200000, 350000,
                                30000, 111999, 112000, 160000};
  localparam bit V_LV  [NV] = '{0, 0, 0, 0, 0, 0, 1, 1, 1, 1};
  localparam int V_P2  [NV] = '{10, 10, 10, 10, 5, 5, 14, 14, 7, 7};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, start1 = 1'b0;
  logic lvds_mode = 1'b0;
  logic [TGT_W-1:0] target_khz = '0;

  logic busy, done, found, dual_chan;
  logic [3:0] n_div, p1_div, p2_div;
  logic [4:0] m1_div;
  logic [2:0] m2_div;
  logic [DOT_W-1:0] dot_khz;
  logic [23:0] fp_word;
  logic [31:0] post_word;

  logic busy1, done1, found1, dual1;
  logic [3:0] n1, p11, p21;
  logic [4:0] m11;
  logic [2:0] m21;
  logic [DOT_W-1:0] dot1;
  logic [23:0] fp1;
  logic [31:0] post1;

  int n_chk = 0;
  int n_err = 0;

  always #10 clk = ~clk;

  pll_div_search #(.TGT_W(TGT_W), .DOT_W(DOT_W)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .lvds_mode(lvds_mode),
    .target_khz(target_khz), .busy(busy), .done(done), .found(found),
    .n_div(n_div), .m1_div(m1_div), .m2_div(m2_div), .p1_div(p1_div),
    .p2_div(p2_div), .dual_chan(dual_chan), .dot_khz(dot_khz),
    .fp_word(fp_word), .post_word(post_word));

  // VCO window made empty: nothing can be legal
  pll_div_search #(.TGT_W(TGT_W), .DOT_W(DOT_W), .VCO_MIN_KHZ(3000000)) u1 (
    .clk(clk), .rst_n(rst_n), .start(start1), .lvds_mode(lvds_mode),
    .target_khz(target_khz), .busy(busy1), .done(done1), .found(found1),
    .n_div(n1), .m1_div(m11), .m2_div(m21), .p1_div(p11),
    .p2_div(p21), .dual_chan(dual1), .dot_khz(dot1),
    .fp_word(fp1), .post_word(post1));

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model(input int tgt, input bit lv, output bit f,
                       output int bn, output int bm1, output int bm2,
                       output int bp1, output longint bdot);
    int p2, plo, phi;
    longint b_err, b_den;
    p2  = lv ? ((tgt < 112000) ? 14 : 7) : ((tgt < 200000) ? 10 : 5);
    plo = lv ? 7 : 5;
    phi = lv ? 98 : 80;
    f = 0; bn = 0; bm1 = 0; bm2 = 0; bp1 = 0; bdot = 0; b_err = 0; b_den = 1;
    for (int n = 1; n <= 6; n++)
      for (int m1 = 8; m1 <= 18; m1++)
        for (int m2 = 3; m2 <= 7; m2++)
          for (int p1 = 1; p1 <= 8; p1++) begin
            longint m, p, a, dn, vco, dot, e;
            m = 5 * (m1 + 2) + (m2 + 2);
            p = p1 * p2;
            a = 96000 * m;
            dn = (n + 2) * p;
            vco = a / (n + 2);
            dot = vco / p;
            if (m < 70 || m > 120 || p < plo || p > phi) continue;
            if (vco < 1400000 || vco > 2800000 || dot < 20000 || dot > 400000) continue;
            e = a - longint'(tgt) * dn;
            if (e < 0) e = -e;
            if (!f || e * b_den < b_err * dn) begin
              f = 1; bn = n; bm1 = m1; bm2 = m2; bp1 = p1; bdot = dot;
              b_err = e; b_den = dn;
            end
          end
  endtask

  task automatic request(input bit lv, input int tgt, output int lat);
    @(negedge clk);
    lvds_mode = lv;
    target_khz = TGT_W'(tgt);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!done) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic check_result(input bit lv, input int tgt, input int exp_p2);
    bit f;
    int en, em1, em2, ep1;
    longint edot, m, p, vco, dot;
    model(tgt, lv, f, en, em1, em2, ep1, edot);
    chk(found == 1'b1, "R3 found", found, 1);
    chk(int'(p2_div) == exp_p2, "R2 p2", p2_div, exp_p2);
    chk(int'(n_div) == en && int'(m1_div) == em1 && int'(m2_div) == em2 && int'(p1_div) == ep1,
        "R4 nearest divider set", {n_div, m1_div, m2_div, p1_div}, {4'(en), 5'(em1), 3'(em2), 4'(ep1)});
    chk(longint'(dot_khz) == edot, "R5 dot", dot_khz, edot);
    chk(fp_word == 24'((en << 16) | (em1 << 8) | em2), "R6 fp_word", fp_word,
        (en << 16) | (em1 << 8) | em2);
    chk(post_word == (32'd1 << (15 + ep1)), "R7 post_word", post_word, 64'd1 << (15 + ep1));
    chk(dual_chan == (lv && exp_p2 == 7), "R8 dual", dual_chan, lv && exp_p2 == 7);
    m = 5 * (m1_div + 2) + (m2_div + 2);
    p = p1_div * p2_div;
    vco = (p1_div == 0) ? 0 : 96000 * m / (n_div + 2);
    dot = (p == 0) ? 0 : vco / p;
    chk(m >= 70 && m <= 120 && p >= (lv ? 7 : 5) && p <= (lv ? 98 : 80) &&
        vco >= 1400000 && vco <= 2800000 && dot >= 20000 && dot <= 400000,
        "R3 derived ranges", dot, 20000);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    int lat;
    repeat (3) @(negedge clk);
    chk(busy == 0 && done == 0, "R12 reset busy/done", {busy, done}, 0);
    chk(found == 0 && post_word == 0, "R12 reset found/post", post_word, 0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      request(V_LV[i], V_TGT[i], lat);
      chk(lat <= LAT_MAX, "R10 latency", lat, LAT_MAX);
      check_result(V_LV[i], V_TGT[i], V_P2[i]);
      @(negedge clk);
      chk(done == 0 && busy == 0, "R10 single done strobe", {busy, done}, 0);
    end

    // R1: second request while busy is ignored
    @(negedge clk);
    lvds_mode = 1'b0; target_khz = TGT_W'(65000); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (100) @(negedge clk);
    chk(busy == 1, "R1 busy during scan", busy, 1);
    lvds_mode = 1'b1; target_khz = TGT_W'(160000); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lvds_mode = 1'b0; target_khz = TGT_W'(65000);
    while (!done) @(negedge clk);
    check_result(1'b0, 65000, 10);
    @(negedge clk);
    chk(busy == 0, "R1 no second search started", busy, 0);

    // R11: outputs hold while idle even when inputs move
    begin
      logic [23:0] fp_s;
      logic [DOT_W-1:0] dot_s;
      logic [31:0] post_s;
      fp_s = fp_word; dot_s = dot_khz; post_s = post_word;
      lvds_mode = 1'b1; target_khz = TGT_W'(300000);
      repeat (30) @(negedge clk);
      chk(fp_word == fp_s && dot_khz == dot_s && post_word == post_s && found == 1,
          "R11 idle hold", fp_word, fp_s);
    end

    // R9: empty legal set
    @(negedge clk);
    lvds_mode = 1'b0; target_khz = TGT_W'(100000); start1 = 1'b1;
    @(negedge clk);
    start1 = 1'b0;
    while (!done1) @(negedge clk);
    chk(found1 == 0, "R9 found low", found1, 0);
    chk(dot1 == 0 && post1 == 0 && fp1 == 0 && p21 == 0 && dual1 == 0,
        "R9 zero outputs", {dot1, post1}, 0);

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule